// File: doc/BRIEF.md
# SD Host Command Issue and Response Capture

This block is the command side of an SD host controller. Software loads a 32-bit argument and then a 16-bit command word. The command word holds a 6-bit command index and several flag bits. When software writes the word with the start flag set, the block sends the index and the stored argument to a card-side responder over a valid/ready request channel. It then waits for the responder's reply on a valid/ready response channel.

The reply carries a byte count, up to sixteen response bytes and an error flag. The block checks the byte count against the response-kind flags of the command and packs accepted bytes into four 32-bit response words. On success it can raise a busy-completion interrupt. On failure it marks the command as failed and sets a timeout bit in the host status.

A small configuration register holds the interrupt enable. The status register is cleared by writing ones. The serial command line, CRC generation and card clock division are not part of this block.

Top module: `sdcmd_issue`

## Requirements
- R1: After reset the command word, argument, status, response words and interrupt enable are all zero, and neither handshake signal (`req_valid_o`, `rsp_ready_o`) is asserted.
- R2: Register writes use `reg_sel_i`: 0 selects the command word, 1 the argument, 2 the configuration, 3 the status clear. A command write stores `reg_wdata_i[15:0]` on `cmd_o`. The command word's bit fields are: bit 15 start, bit 14 fail, bit 11 busy-wait, bit 10 no-response, bit 9 long response, bits 5:0 index. If bit 15 is written as 1, `req_valid_o` rises on the next cycle with `req_index_o` equal to the index and `req_arg_o` equal to the stored argument. Bit 15 then reads 1 until the response handshake completes and reads 0 from the cycle after it.
- R3: While a command is outstanding (from the start write until the response handshake completes), writes to the command word and to the argument are ignored.
- R4: `req_valid_o` and its payload stay constant until `req_ready_i` is seen. `rsp_ready_o` is asserted only after the request has been accepted, never in the same cycle as `req_valid_o`.
- R5: With the no-response flag clear, the command fails if the reply length is 0, if it is 4 while the long-response flag is set, or if it is any value other than 4 or 16. A failed command sets command bit 14 and status bit 6 and leaves the response words unchanged.
- R6: A reply with `resp_err_i` set fails the command in the same way as R5, whatever the response flags are.
- R7: Response byte k sits at `rsp_bytes_i[8k+7:8k]`, and response word n sits at `rsp_o[32n+31:32n]`. An accepted 4-byte reply loads word 0 as {byte0, byte1, byte2, byte3} and clears words 1 to 3.
- R8: An accepted 16-byte reply loads each word n from bytes 4(3-n) to 4(3-n)+3, with the lowest-numbered byte in the word's top bits. This applies even when the long-response flag is clear.
- R9: With the no-response flag set and no reply error, the command succeeds whatever the reply length, and the response words are left unchanged.
- R10: A successful command with the busy-wait flag set sets status bit 10 if configuration bit 10 was set. `irq_o` follows status bit 10. A failed command, or a busy-wait command with the enable clear, does not set status bit 10.
- R11: A status write clears each status bit whose data bit is 1. If a completion sets a bit in the same cycle as a write clears it, the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 command, 1 argument, 2 config, 3 status clear) |
| reg_wdata_i | input | 32 | Register write data |
| cmd_o | output | 16 | Current command word, including start and fail bits |
| status_o | output | 11 | Host status (bit 10 busy done, bit 6 command timeout) |
| rsp_o | output | 128 | Four response words, word 0 in the low bits |
| irq_o | output | 1 | Interrupt request |
| req_valid_o | output | 1 | Request to responder valid |
| req_ready_i | input | 1 | Responder accepts request |
| req_index_o | output | 6 | Command index of the request |
| req_arg_o | output | 32 | Command argument of the request |
| rsp_valid_i | input | 1 | Responder reply valid |
| rsp_ready_o | output | 1 | Block waits for a reply |
| rsp_len_i | input | 5 | Reply byte count |
| rsp_bytes_i | input | 128 | Reply bytes, byte k at bits 8k+7:8k |
| rsp_err_i | input | 1 | Responder reports no valid reply |

## Verification
A wrong handshake phase shows on the next clock as a request valid or response ready that the reference model does not expect, or as the start bit of `cmd_o` reading back at the wrong level. A wrong length decision or a wrong byte order shows on `rsp_o`, `status_o` bit 6 or `cmd_o` bit 14 in the first cycle after the reply is accepted. A bad interrupt enable or clear shows on `irq_o` in that same cycle. The bench compares every output with its model on every clock. Directed cases cover each length corner, both word orders, writes during an outstanding command, and clear-versus-set ordering.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int CMD_W      = 16;
    localparam int IDX_W      = 6;
    localparam int STAT_W     = 11;

    localparam int START_B    = 15;
    localparam int FAIL_B     = 14;
    localparam int BUSYW_B    = 11;
    localparam int NORSP_B    = 10;
    localparam int LONG_B     = 9;

    localparam int ST_BUSY_B  = 10;
    localparam int ST_TOUT_B  = 6;
    localparam int CFG_BUSY_B = 10;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_ARG  = 2'd1,
        SEL_CFG  = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

endpackage

// File: rtl/sdcmd_handshake.sv
module sdcmd_handshake
    import sdcmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic req_ready_i,
    input  logic rsp_valid_i,
    output logic req_valid_o,
    output logic rsp_ready_o,
    output logic done_o,
    output logic busy_o
);

    typedef struct packed {
        phase_e phase;
    } hs_state_t;

    hs_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: if (start_i)     st_d.phase = PH_REQ;
            PH_REQ:  if (req_ready_i) st_d.phase = PH_WAIT;
            PH_WAIT: if (rsp_valid_i) st_d.phase = PH_IDLE;
            default:                  st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE};
        else        st_q <= st_d;
    end

    assign req_valid_o = (st_q.phase == PH_REQ);
    assign rsp_ready_o = (st_q.phase == PH_WAIT);
    assign done_o      = (st_q.phase == PH_WAIT) && rsp_valid_i;
    assign busy_o      = (st_q.phase != PH_IDLE);

endmodule

// File: rtl/sdcmd_resp_eval.sv
module sdcmd_resp_eval #(
    parameter int WORD_W    = 32,
    parameter int RSP_BYTES = 16,
    localparam int WB       = WORD_W / 8,
    localparam int WORDS    = RSP_BYTES / WB,
    localparam int RSP_W    = RSP_BYTES * 8,
    localparam int LEN_W    = $clog2(RSP_BYTES) + 1
) (
    input  logic             no_rsp_i,
    input  logic             long_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [RSP_W-1:0] bytes_i,
    input  logic             err_i,
    output logic             fail_o,
    output logic             load_o,
    output logic [RSP_W-1:0] words_o
);

    localparam logic [LEN_W-1:0] SHORT_LEN = LEN_W'(WB);
    localparam logic [LEN_W-1:0] LONG_LEN  = LEN_W'(RSP_BYTES);

    logic [RSP_W-1:0] long_words;
    logic [RSP_W-1:0] short_words;
    logic             len_bad;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < WB; b++) begin : g_byte
            assign long_words[w*WORD_W + (WB-1-b)*8 +: 8] =
                bytes_i[((WORDS-1-w)*WB + b)*8 +: 8];
            if (w == 0) begin : g_short0
                assign short_words[(WB-1-b)*8 +: 8] = bytes_i[b*8 +: 8];
            end else begin : g_shortz
                assign short_words[w*WORD_W + (WB-1-b)*8 +: 8] = 8'h00;
            end
        end
    end

    always_comb begin
        len_bad = 1'b0;
        if (len_i == '0)                            len_bad = 1'b1;
        if (len_i == SHORT_LEN && long_i)           len_bad = 1'b1;
        if (len_i != SHORT_LEN && len_i != LONG_LEN) len_bad = 1'b1;

        if (no_rsp_i) begin
            fail_o = err_i;
            load_o = 1'b0;
        end else begin
            fail_o = err_i | len_bad;
            load_o = ~(err_i | len_bad);
        end
        words_o = (len_i == LONG_LEN) ? long_words : short_words;
    end

endmodule

// File: rtl/sdcmd_issue.sv
module sdcmd_issue
    import sdcmd_pkg::*;
#(
    parameter int ARG_W     = 32,
    parameter int RSP_BYTES = 16,
    localparam int RSP_W    = RSP_BYTES * 8,
    localparam int LEN_W    = $clog2(RSP_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we_i,
    input  logic [1:0]        reg_sel_i,
    input  logic [ARG_W-1:0]  reg_wdata_i,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [STAT_W-1:0] status_o,
    output logic [RSP_W-1:0]  rsp_o,
    output logic              irq_o,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [IDX_W-1:0]  req_index_o,
    output logic [ARG_W-1:0]  req_arg_o,
    input  logic              rsp_valid_i,
    output logic              rsp_ready_o,
    input  logic [LEN_W-1:0]  rsp_len_i,
    input  logic [RSP_W-1:0]  rsp_bytes_i,
    input  logic              rsp_err_i
);

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [ARG_W-1:0]  arg;
        logic              busy_en;
        logic [STAT_W-1:0] status;
        logic [RSP_W-1:0]  rsp;
    } regs_t;

    regs_t r_d, r_q;

    logic             hs_busy, hs_done, start;
    logic             ev_fail, ev_load;
    logic [RSP_W-1:0] ev_words;
    logic             wr_cmd, wr_arg, wr_cfg, wr_stat;

    always_comb begin
        wr_cmd  = reg_we_i && (reg_sel_i == SEL_CMD)  && !hs_busy;
        wr_arg  = reg_we_i && (reg_sel_i == SEL_ARG)  && !hs_busy;
        wr_cfg  = reg_we_i && (reg_sel_i == SEL_CFG);
        wr_stat = reg_we_i && (reg_sel_i == SEL_STAT);
        start   = wr_cmd && reg_wdata_i[START_B];
    end

    sdcmd_handshake u_hs (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .req_ready_i (req_ready_i),
        .rsp_valid_i (rsp_valid_i),
        .req_valid_o (req_valid_o),
        .rsp_ready_o (rsp_ready_o),
        .done_o      (hs_done),
        .busy_o      (hs_busy)
    );

    sdcmd_resp_eval #(
        .WORD_W    (32),
        .RSP_BYTES (RSP_BYTES)
    ) u_eval (
        .no_rsp_i (r_q.cmd[NORSP_B]),
        .long_i   (r_q.cmd[LONG_B]),
        .len_i    (rsp_len_i),
        .bytes_i  (rsp_bytes_i),
        .err_i    (rsp_err_i),
        .fail_o   (ev_fail),
        .load_o   (ev_load),
        .words_o  (ev_words)
    );

    always_comb begin
        r_d = r_q;
        if (wr_cmd)  r_d.cmd     = reg_wdata_i[CMD_W-1:0];
        if (wr_arg)  r_d.arg     = reg_wdata_i;
        if (wr_cfg)  r_d.busy_en = reg_wdata_i[CFG_BUSY_B];
        if (wr_stat) r_d.status  = r_q.status & ~reg_wdata_i[STAT_W-1:0];
        if (hs_done) begin
            r_d.cmd[START_B] = 1'b0;
            if (ev_fail) begin
                r_d.cmd[FAIL_B]       = 1'b1;
                r_d.status[ST_TOUT_B] = 1'b1;
            end else begin
                if (ev_load) r_d.rsp = ev_words;
                if (r_q.cmd[BUSYW_B] && r_q.busy_en)
                    r_d.status[ST_BUSY_B] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmd_o       = r_q.cmd;
    assign status_o    = r_q.status;
    assign rsp_o       = r_q.rsp;
    assign irq_o       = r_q.status[ST_BUSY_B];
    assign req_index_o = r_q.cmd[IDX_W-1:0];
    assign req_arg_o   = r_q.arg;

endmodule

// File: rtl/sdcmd_issue_chk.sv
module sdcmd_issue_chk #(
    parameter int ARG_W     = 32,
    parameter int RSP_BYTES = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid_o,
    input logic                   req_ready_i,
    input logic [5:0]             req_index_o,
    input logic [ARG_W-1:0]       req_arg_o,
    input logic                   rsp_valid_i,
    input logic                   rsp_ready_o,
    input logic                   rsp_err_i,
    input logic [15:0]            cmd_o,
    input logic [10:0]            status_o,
    input logic [RSP_BYTES*8-1:0] rsp_o
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_index_o) && $stable(req_arg_o)); // R4

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid_o && rsp_ready_o)); // R4

    AST_START_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> cmd_o[15]); // R2

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_i && rsp_ready_o |=> !cmd_o[15]); // R2

    AST_ERR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_i && rsp_ready_o && rsp_err_i |=> cmd_o[14] && status_o[6]); // R6

    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid_i && rsp_ready_o) |=> $stable(rsp_o)); // R5

    AST_BUSY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[10]) |-> $past(rsp_valid_i && rsp_ready_o && !rsp_err_i)); // R10

endmodule

bind sdcmd_issue sdcmd_issue_chk #(
    .ARG_W     (ARG_W),
    .RSP_BYTES (RSP_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_index_o (req_index_o),
    .req_arg_o   (req_arg_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_ready_o (rsp_ready_o),
    .rsp_err_i   (rsp_err_i),
    .cmd_o       (cmd_o),
    .status_o    (status_o),
    .rsp_o       (rsp_o)
);

// File: tb/sdcmd_issue_bench.sv
module sdcmd_issue_bench;
    import sdcmd_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [1:0]   reg_sel = 2'd0;
    logic [31:0]  reg_wdata = '0;
    logic [15:0]  cmd;
    logic [10:0]  status;
    logic [127:0] rsp;
    logic         irq, req_valid, rsp_ready;
    logic         req_ready = 1'b0;
    logic [5:0]   req_index;
    logic [31:0]  req_arg;
    logic         rsp_valid = 1'b0;
    logic [4:0]   rsp_len = '0;
    logic [127:0] rsp_bytes = '0;
    logic         rsp_err = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdcmd_issue u_sdcmd_issue (
        .clk(clk), .rst_n(rst_n),
        .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
        .cmd_o(cmd), .status_o(status), .rsp_o(rsp), .irq_o(irq),
        .req_valid_o(req_valid), .req_ready_i(req_ready),
        .req_index_o(req_index), .req_arg_o(req_arg),
        .rsp_valid_i(rsp_valid), .rsp_ready_o(rsp_ready),
        .rsp_len_i(rsp_len), .rsp_bytes_i(rsp_bytes), .rsp_err_i(rsp_err)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int          m_phase;
    logic [15:0] m_cmd;
    logic [31:0] m_arg;
    logic        m_en;
    logic [10:0] m_stat;
    logic [127:0] m_rsp;

    function automatic logic [31:0] grp(input logic [127:0] b, input int g);
        return {b[(4*g)*8 +: 8], b[(4*g+1)*8 +: 8], b[(4*g+2)*8 +: 8], b[(4*g+3)*8 +: 8]};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_cmd = '0; m_arg = '0; m_en = 0; m_stat = '0; m_rsp = '0;
        end else begin
            int  ph;
            bit  bad;
            ph = m_phase;
            if (reg_we) begin
                case (reg_sel)
                    2'd0: if (ph == 0) begin
                        m_cmd = reg_wdata[15:0];
                        if (reg_wdata[15]) m_phase = 1;
                    end
                    2'd1: if (ph == 0) m_arg = reg_wdata;
                    2'd2: m_en = reg_wdata[10];
                    default: m_stat = m_stat & ~reg_wdata[10:0];
                endcase
            end
            if (ph == 1 && req_ready) m_phase = 2;
            if (ph == 2 && rsp_valid) begin
                m_phase = 0;
                m_cmd[15] = 1'b0;
                bad = rsp_err;
                if (!m_cmd[10] && (rsp_len == 0 || (rsp_len == 4 && m_cmd[9]) ||
                                   (rsp_len != 4 && rsp_len != 16))) bad = 1;
                if (bad) begin
                    m_cmd[14] = 1'b1;
                    m_stat[6] = 1'b1;
                end else begin
                    if (!m_cmd[10])
                        m_rsp = (rsp_len == 4) ? {96'h0, grp(rsp_bytes, 0)}
                              : {grp(rsp_bytes, 0), grp(rsp_bytes, 1), grp(rsp_bytes, 2), grp(rsp_bytes, 3)};
                    if (m_cmd[11] && m_en) m_stat[10] = 1'b1;
                end
            end
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 cmd_o model", {112'h0, cmd}, {112'h0, m_cmd});
            chk("R10 status_o model", {117'h0, status}, {117'h0, m_stat});
            chk("R8 rsp_o model", rsp, m_rsp);
            chk("R10 irq_o model", {127'h0, irq}, {127'h0, m_stat[10]});
            chk("R4 handshake model", {126'h0, req_valid, rsp_ready},
                {126'h0, m_phase == 1, m_phase == 2});
            if (m_phase == 1)
                chk("R4 request payload", {90'h0, req_index, req_arg}, {90'h0, m_cmd[5:0], m_arg});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic serve(input logic [4:0] len, input logic [127:0] b, input logic err, input int delay);
        repeat (delay) @(negedge clk);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        rsp_valid = 1'b1; rsp_len = len; rsp_bytes = b; rsp_err = err;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0;
    endtask

    task automatic issue(input logic [15:0] w, input logic [4:0] len, input logic [127:0] b, input logic err);
        wr(SEL_CMD, {16'h0, w});
        serve(len, b, err, 0);
    endtask

    localparam logic [127:0] PAT0 = 128'hFFEEDDCC_BBAA9988_77665544_33221100; // byte k = k*0x11
    localparam logic [127:0] PAT1 = 128'hAFAEADAC_ABAAA9A8_A7A6A5A4_A3A2A1A0; // byte k = 0xA0+k

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cmd reset", {112'h0, cmd}, '0);
        chk("R1 status reset", {117'h0, status}, '0);
        chk("R1 rsp reset", rsp, '0);
        chk("R1 handshake idle", {126'h0, req_valid, rsp_ready}, '0);

        // R2 plain write without start
        wr(SEL_ARG, 32'h1234_5678);
        wr(SEL_CMD, 32'h0000_0203);
        chk("R2 store without start", {112'h0, cmd}, 128'h0203);
        chk("R2 no request", {127'h0, req_valid}, '0);

        // R2/R7 short reply
        wr(SEL_CMD, 32'h0000_8011);
        chk("R2 start reads back", {127'h0, cmd[15]}, 128'h1);
        chk("R2 request index/arg", {90'h0, req_valid, req_index, req_arg}, {90'h0, 1'b1, 6'h11, 32'h1234_5678});
        serve(5'd4, PAT1, 1'b0, 2);
        chk("R7 short pack", rsp, 128'hA0A1A2A3);
        chk("R2 start cleared", {112'h0, cmd}, 128'h0011);

        // R8 long reply, reversed word order
        issue(16'h8202, 5'd16, PAT0, 1'b0);
        chk("R8 long pack", rsp, 128'h00112233_44556677_8899AABB_CCDDEEFF);
        // R8 16 bytes with long flag clear
        issue(16'h8003, 5'd16, PAT1, 1'b0);
        chk("R8 long bytes short flag", rsp, 128'hA0A1A2A3_A4A5A6A7_A8A9AAAB_ACADAEAF);

        // R5 length errors
        issue(16'h8205, 5'd4, PAT0, 1'b0);
        chk("R5 long wants 16", {112'h0, cmd}, 128'h4205);
        chk("R5 timeout bit", {127'h0, status[6]}, 128'h1);
        chk("R5 rsp unchanged", rsp, 128'hA0A1A2A3_A4A5A6A7_A8A9AAAB_ACADAEAF);
        wr(SEL_STAT, 32'h0000_07FF);
        chk("R11 status cleared", {117'h0, status}, '0);
        issue(16'h8006, 5'd0, PAT0, 1'b0);
        chk("R5 zero length", {127'h0, status[6]}, 128'h1);
        wr(SEL_STAT, 32'h40);
        issue(16'h8007, 5'd8, PAT0, 1'b0);
        chk("R5 length 8", {126'h0, cmd[14], status[6]}, 128'h3);
        chk("R5 rsp unchanged 8", rsp, 128'hA0A1A2A3_A4A5A6A7_A8A9AAAB_ACADAEAF);
        wr(SEL_STAT, 32'h40);

        // R6 responder error, also with no-response flag
        issue(16'h8408, 5'd16, PAT0, 1'b1);
        chk("R6 error with no-response", {126'h0, cmd[14], status[6]}, 128'h3);
        wr(SEL_STAT, 32'h40);

        // R9 no-response ignores length
        issue(16'h8409, 5'd0, PAT0, 1'b0);
        chk("R9 no error", {126'h0, cmd[14], status[6]}, '0);
        chk("R9 rsp unchanged", rsp, 128'hA0A1A2A3_A4A5A6A7_A8A9AAAB_ACADAEAF);

        // R10 busy interrupt
        issue(16'h880A, 5'd4, PAT0, 1'b0);
        chk("R10 busy without enable", {127'h0, irq}, '0);
        wr(SEL_CFG, 32'h400);
        issue(16'h880B, 5'd4, PAT0, 1'b0);
        chk("R10 busy irq set", {116'h0, irq, status}, {116'h0, 1'b1, 11'h400});
        wr(SEL_STAT, 32'h400);
        chk("R11 irq cleared", {127'h0, irq}, '0);
        issue(16'h8A0C, 5'd4, PAT0, 1'b0);
        chk("R10 no busy on fail", {117'h0, status}, 128'h40);
        wr(SEL_STAT, 32'h40);

        // R11 clear in the completion cycle: set wins
        wr(SEL_CMD, 32'h880D);
        @(negedge clk); req_ready = 1'b1;
        @(negedge clk); req_ready = 1'b0;
        rsp_valid = 1'b1; rsp_len = 5'd4; rsp_bytes = PAT0;
        reg_we = 1'b1; reg_sel = SEL_STAT; reg_wdata = 32'h400;
        @(negedge clk);
        rsp_valid = 1'b0; reg_we = 1'b0;
        chk("R11 set beats clear", {127'h0, status[10]}, 128'h1);
        wr(SEL_STAT, 32'h7FF);

        // R3 writes ignored while outstanding
        wr(SEL_ARG, 32'hCAFE_0001);
        wr(SEL_CMD, 32'h0000_800E);
        wr(SEL_CMD, 32'h0000_8025);
        wr(SEL_ARG, 32'hDEAD_BEEF);
        chk("R3 request unchanged", {90'h0, req_valid, req_index, req_arg}, {90'h0, 1'b1, 6'h0E, 32'hCAFE_0001});
        serve(5'd4, PAT1, 1'b0, 1);
        chk("R3 cmd kept", {112'h0, cmd}, 128'h000E);
        wr(SEL_CMD, 32'h0000_8000);
        chk("R3 arg kept", {96'h0, req_arg}, 128'hCAFE_0001);
        serve(5'd4, PAT0, 1'b0, 0);
        chk("R7 short clears upper", rsp, 128'h00112233);

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule